// File: doc/BRIEF.md
# Ethernet controller command and interrupt registers

This block is the host-facing register file of a descriptor-driven Ethernet MAC. A host selects one of 64 sixteen-bit registers with a 6-bit index. A write takes effect on the clock edge that samples it. A read returns the selected register combinationally. One index holds the command register. Writing it launches or stops work in neighbouring engines: the transmitter, the receive-resource fetcher, the address-filter loader, the general timer and the receiver. Each launch leaves the block as a registered one-cycle pulse.

A mask register and a status register drive a single level interrupt line. The engines report events through per-bit status-set inputs. They also return "done" strobes that retire their command bits. Every other index follows its own write rule: stored in full, stored through a writable mask, accepted only while the controller sits in software reset, stored inverted, read-only, or absent.

Top module: `enet_ctl_regs`

## Requirements
- R1: After hardware reset the registers read as follows. Command (index 0x00) is 0x0094. Transmit control (0x03) is 0x0101. Receive control (0x02) is 0x0020. End-of-buffer count (0x13) is 0x02F8. Mask (0x04) and status (0x05) are 0. Revision (0x28) is 0x0004. The irq output is low.
- R2: While command bit 7 (reset) is set, a command write with bit 7 clear only clears bit 7. No other command bit changes and no launch pulse is produced.
- R3: Command bit positions are: halt 0, transmit 1, receiver-disable 2, receiver-enable 3, timer-stop 4, timer-start 5, reset 7, resource-read 8, filter-load 9. Command writes OR in only the bits of 0x03BF. In the cycle after an accepted write, the output pulses fire for the written bits: go_tx for bit 1, go_rx_dis for bit 2, go_rx_en for bit 3, go_tmr_stop for bit 4, go_tmr_start for bit 5, go_rra for bit 8, go_cam for bit 9. Each pulse lasts one cycle.
- R4: Receiver-enable and receiver-disable are never both set, and neither are timer-start and timer-stop. Writing one bit of a pair clears the other. A write that sets both bits of a pair leaves the enable or start bit set and the other clear.
- R5: An accepted command write with bit 7 set clears bits 9, 8, 1 and 0 and bit 3, and sets bits 7 and 2. It produces a go_rx_dis pulse and no go_tx, go_rra or go_cam pulse.
- R6: tx_done clears command bit 1 and cam_done clears command bit 9. Command bit 8 reads 1 in the cycle after it is written and 0 one cycle later.
- R7: Mask writes never store bit 15. irq is high exactly when the mask and status registers share a set bit.
- R8: A status write clears the bits written as 1. A bit raised on sts_set in the same cycle stays set. A status write that clears a set bit 5 (resource exhausted) pulses go_rra in the next cycle. Writing 1 to bit 5 while it is already clear produces no pulse.
- R9: Index 0x01 stores data AND 0xBFFF and index 0x3F stores data AND 0xF017. Writes to either index are accepted only while command bit 7 is set.
- R10: Index 0x03 keeps data bits 15:12 and index 0x02 keeps data bits 15:5. Indices 0x15 to 0x18 store data with bit 0 forced to 0.
- R11: Indices 0x2C, 0x2D and 0x2E store data XOR 0xFFFF. Index 0x28 always reads 0x0004. Indices 0x22 to 0x24 and 0x2F read 0. None of these read-only indices changes when written.
- R12: Indices 0x1B to 0x1E and 0x30 to 0x3E read 0 after any write. Every other index not named above, such as 0x06 and 0x25, stores all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_wr | input | 1 | Write strobe for the selected register |
| host_idx | input | 6 | Register index for write and read |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the indexed register |
| sts_set | input | 16 | Per-bit status-set strobes from the engines |
| tx_done | input | 1 | Transmit engine finished |
| cam_done | input | 1 | Address filter load finished |
| go_tx | output | 1 | Launch transmission |
| go_rra | output | 1 | Request a receive-resource read |
| go_cam | output | 1 | Launch address filter load |
| go_tmr_start | output | 1 | Start the general timer |
| go_tmr_stop | output | 1 | Stop the general timer |
| go_rx_en | output | 1 | Enable the receiver |
| go_rx_dis | output | 1 | Disable the receiver |
| irq | output | 1 | Level interrupt |

## Verification
A vector table writes all ones, partial patterns and alternating patterns to one index of every write-rule class while the controller is still in reset. Reading each index back separates masked storage from inverted, reset-gated, constant and absent registers. Directed command sequences follow. The first write leaving reset carries a transmit bit, which shows that the write is swallowed. Single writes, paired writes and writes that set both bits of a pair separate the merge ordering from a plain OR. A reset command issued over pending launches checks which bits survive. Status tests inject a masked top bit, a partial clear, a clear of an already-clear bit and a set that coincides with a clear. Together these separate write-one-to-clear from plain writes and show the set priority and the resource-read request.

// File: rtl/enet_regs_pkg.sv
package enet_regs_pkg;

   localparam int unsigned REG_W = 16;
   localparam int unsigned IDX_W = 6;

   localparam logic [5:0] IX_CMD      = 6'h00;
   localparam logic [5:0] IX_IMASK    = 6'h04;
   localparam logic [5:0] IX_ISTAT    = 6'h05;

   localparam int CB_HALT  = 0;
   localparam int CB_TX    = 1;
   localparam int CB_RXDIS = 2;
   localparam int CB_RXEN  = 3;
   localparam int CB_STOP  = 4;
   localparam int CB_START = 5;
   localparam int CB_SRST  = 7;
   localparam int CB_RRA   = 8;
   localparam int CB_CAM   = 9;
   localparam logic [15:0] CMD_KEEP = 16'h03BF;
   localparam logic [15:0] CMD_RST_VAL = 16'h0094;

   localparam int RBE_BIT = 5;
   localparam logic [15:0] IMR_KEEP = 16'h7FFF;
   localparam logic [15:0] REV_CODE = 16'h0004;

   typedef enum logic [2:0] {
      RK_HOLE, RK_CORE, RK_CONST, RK_RDZERO,
      RK_PLAIN, RK_MASKED, RK_RSTONLY, RK_INVERT
   } reg_kind_e;

   typedef struct packed {
      logic tx;
      logic rra;
      logic cam;
      logic tmr_start;
      logic tmr_stop;
      logic rx_en;
      logic rx_dis;
   } cmd_pulse_t;

   function automatic reg_kind_e kind_of(input logic [5:0] ix);
      reg_kind_e k;
      if (ix == IX_CMD || ix == IX_IMASK || ix == IX_ISTAT)  k = RK_CORE;
      else if ((ix >= 6'h1B && ix <= 6'h1E) || (ix >= 6'h30 && ix <= 6'h3E))
                                                             k = RK_HOLE;
      else if (ix == 6'h01 || ix == 6'h3F)                   k = RK_RSTONLY;
      else if (ix == 6'h02 || ix == 6'h03 || (ix >= 6'h15 && ix <= 6'h18))
                                                             k = RK_MASKED;
      else if ((ix >= 6'h22 && ix <= 6'h24) || ix == 6'h2F)  k = RK_RDZERO;
      else if (ix == 6'h28)                                  k = RK_CONST;
      else if (ix >= 6'h2C && ix <= 6'h2E)                   k = RK_INVERT;
      else                                                   k = RK_PLAIN;
      return k;
   endfunction

   function automatic logic [15:0] wmask_of(input logic [5:0] ix);
      logic [15:0] m;
      case (ix)
         6'h01:                      m = 16'hBFFF;
         6'h3F:                      m = 16'hF017;
         6'h02:                      m = 16'hFFE0;
         6'h03:                      m = 16'hF000;
         6'h15, 6'h16, 6'h17, 6'h18: m = 16'hFFFE;
         default:                    m = 16'hFFFF;
      endcase
      return m;
   endfunction

   function automatic logic [15:0] rstval_of(input logic [5:0] ix);
      logic [15:0] v;
      case (ix)
         6'h02:   v = 16'h0020;
         6'h03:   v = 16'h0101;
         6'h13:   v = 16'h02F8;
         default: v = 16'h0000;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/enet_reg_bank.sv
module enet_reg_bank
   import enet_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              in_reset,
   input  logic [ADDR_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned NREG = 1 << ADDR_W;

   logic [NREG-1:0][DATA_W-1:0] slot;

   for (genvar g = 0; g < NREG; g++) begin : g_slot
      localparam reg_kind_e   KIND = kind_of(6'(g));
      localparam logic [15:0] WMSK = wmask_of(6'(g));
      localparam logic [15:0] RVAL = rstval_of(6'(g));

      if (KIND == RK_PLAIN || KIND == RK_MASKED ||
          KIND == RK_RSTONLY || KIND == RK_INVERT) begin : g_store
         logic [DATA_W-1:0] q;
         logic              hit;
         assign hit = wr_en && (wr_idx == ADDR_W'(g)) &&
                      ((KIND != RK_RSTONLY) || in_reset);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= DATA_W'(RVAL);
            else if (hit) begin
               if (KIND == RK_INVERT) q <= ~wr_data;
               else                   q <= wr_data & DATA_W'(WMSK);
            end
         end
         assign slot[g] = q;
      end else if (KIND == RK_CONST) begin : g_const
         assign slot[g] = DATA_W'(REV_CODE);
      end else begin : g_zero
         assign slot[g] = '0;
      end
   end

   assign rd_data = slot[rd_idx];

endmodule

// File: rtl/enet_cmd_unit.sv
module enet_cmd_unit
   import enet_regs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_wr,
   input  logic [15:0] cmd_data,
   input  logic        tx_done,
   input  logic        cam_done,
   output logic [15:0] cr,
   output cmd_pulse_t  pulse
);

   logic [15:0] cr_n;
   cmd_pulse_t  pulse_n;

   always_comb begin
      cr_n    = cr;
      pulse_n = '0;
      if (cr[CB_RRA]) cr_n[CB_RRA] = 1'b0;
      if (tx_done)    cr_n[CB_TX]  = 1'b0;
      if (cam_done)   cr_n[CB_CAM] = 1'b0;
      if (cmd_wr) begin
         if (cr[CB_SRST] && !cmd_data[CB_SRST]) begin
            cr_n[CB_SRST] = 1'b0;
         end else begin
            cr_n = cr_n | (cmd_data & CMD_KEEP);
            if (cmd_data[CB_RXDIS]) cr_n[CB_RXEN]  = 1'b0;
            if (cmd_data[CB_STOP])  cr_n[CB_START] = 1'b0;
            if (cmd_data[CB_RXEN]) begin
               cr_n[CB_RXEN]  = 1'b1;
               cr_n[CB_RXDIS] = 1'b0;
            end
            if (cmd_data[CB_START]) begin
               cr_n[CB_START] = 1'b1;
               cr_n[CB_STOP]  = 1'b0;
            end
            pulse_n.tmr_start = cmd_data[CB_START];
            pulse_n.tmr_stop  = cmd_data[CB_STOP] & ~cmd_data[CB_START];
            if (cmd_data[CB_SRST]) begin
               cr_n[CB_CAM]   = 1'b0;
               cr_n[CB_RRA]   = 1'b0;
               cr_n[CB_TX]    = 1'b0;
               cr_n[CB_HALT]  = 1'b0;
               cr_n[CB_RXEN]  = 1'b0;
               cr_n[CB_SRST]  = 1'b1;
               cr_n[CB_RXDIS] = 1'b1;
               pulse_n.rx_dis = 1'b1;
            end else begin
               pulse_n.tx     = cmd_data[CB_TX];
               pulse_n.rra    = cmd_data[CB_RRA];
               pulse_n.cam    = cmd_data[CB_CAM];
               pulse_n.rx_en  = cmd_data[CB_RXEN];
               pulse_n.rx_dis = cmd_data[CB_RXDIS] & ~cmd_data[CB_RXEN];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr    <= CMD_RST_VAL;
         pulse <= '0;
      end else begin
         cr    <= cr_n;
         pulse <= pulse_n;
      end
   end

endmodule

// File: rtl/enet_irq_unit.sv
module enet_irq_unit
   import enet_regs_pkg::*;
#(
   parameter bit IRQ_FLOP = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mask_wr,
   input  logic        stat_wr,
   input  logic [15:0] wdata,
   input  logic [15:0] sts_set,
   output logic [15:0] imr,
   output logic [15:0] isr,
   output logic        irq,
   output logic        rbe_req
);

   logic [15:0] imr_n;
   logic [15:0] isr_n;
   logic [15:0] clr;

   always_comb begin
      clr   = stat_wr ? wdata : 16'h0000;
      imr_n = mask_wr ? (wdata & IMR_KEEP) : imr;
      isr_n = (isr & ~clr) | sts_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr     <= '0;
         isr     <= '0;
         rbe_req <= 1'b0;
      end else begin
         imr     <= imr_n;
         isr     <= isr_n;
         rbe_req <= clr[RBE_BIT] & isr[RBE_BIT];
      end
   end

   if (IRQ_FLOP) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(imr_n & isr_n);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(imr & isr);
   end

endmodule

// File: rtl/enet_ctl_regs.sv
module enet_ctl_regs
   import enet_regs_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned DATA_W   = 16,
   parameter bit          IRQ_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_idx,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [DATA_W-1:0] sts_set,
   input  logic              tx_done,
   input  logic              cam_done,
   output logic              go_tx,
   output logic              go_rra,
   output logic              go_cam,
   output logic              go_tmr_start,
   output logic              go_tmr_stop,
   output logic              go_rx_en,
   output logic              go_rx_dis,
   output logic              irq
);

   if (DATA_W != REG_W || ADDR_W != IDX_W) begin : g_bad_geometry
      $error("enet_ctl_regs: register map needs 16-bit data and 6-bit index");
   end

   logic [15:0] cr_q;
   logic [15:0] imr_q;
   logic [15:0] isr_q;
   logic [DATA_W-1:0] bank_rdata;
   logic        rbe_req;
   cmd_pulse_t  pulse;
   logic        wr_cmd;
   logic        wr_mask;
   logic        wr_stat;

   assign wr_cmd  = host_wr && (host_idx == ADDR_W'(IX_CMD));
   assign wr_mask = host_wr && (host_idx == ADDR_W'(IX_IMASK));
   assign wr_stat = host_wr && (host_idx == ADDR_W'(IX_ISTAT));

   enet_cmd_unit u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (wr_cmd),
      .cmd_data (16'(host_wdata)),
      .tx_done  (tx_done),
      .cam_done (cam_done),
      .cr       (cr_q),
      .pulse    (pulse)
   );

   enet_irq_unit #(.IRQ_FLOP(IRQ_FLOP)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_wr (wr_mask),
      .stat_wr (wr_stat),
      .wdata   (16'(host_wdata)),
      .sts_set (16'(sts_set)),
      .imr     (imr_q),
      .isr     (isr_q),
      .irq     (irq),
      .rbe_req (rbe_req)
   );

   enet_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_wr),
      .wr_idx   (host_idx),
      .wr_data  (host_wdata),
      .in_reset (cr_q[CB_SRST]),
      .rd_idx   (host_idx),
      .rd_data  (bank_rdata)
   );

   always_comb begin
      if (host_idx == ADDR_W'(IX_CMD))        host_rdata = DATA_W'(cr_q);
      else if (host_idx == ADDR_W'(IX_IMASK)) host_rdata = DATA_W'(imr_q);
      else if (host_idx == ADDR_W'(IX_ISTAT)) host_rdata = DATA_W'(isr_q);
      else                                    host_rdata = bank_rdata;
   end

   assign go_tx        = pulse.tx;
   assign go_rra       = pulse.rra | rbe_req;
   assign go_cam       = pulse.cam;
   assign go_tmr_start = pulse.tmr_start;
   assign go_tmr_stop  = pulse.tmr_stop;
   assign go_rx_en     = pulse.rx_en;
   assign go_rx_dis    = pulse.rx_dis;

endmodule

// File: rtl/enet_ctl_regs_chk.sv
module enet_ctl_regs_chk
   import enet_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [ADDR_W-1:0] host_idx,
   input logic [DATA_W-1:0] host_wdata,
   input logic [DATA_W-1:0] sts_set,
   input logic [15:0]       cr,
   input logic [15:0]       imr,
   input logic [15:0]       isr,
   input logic              go_tx,
   input logic              go_rra,
   input logic              go_cam,
   input logic              go_rx_en,
   input logic              go_tmr_start
);

   logic cmd_w;
   assign cmd_w = host_wr && (host_idx == ADDR_W'(IX_CMD));

   assert_exit_swallow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && cr[7] && !host_wdata[7]) |=>
      (!cr[7] && !go_tx && !go_rra && !go_cam && !go_rx_en && !go_tmr_start));

   assert_kept_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cr & ~CMD_KEEP) == 16'h0000);

   assert_rx_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cr[3] && cr[2]));

   assert_tmr_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cr[5] && cr[4]));

   assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && !cr[7] && host_wdata[7]) |=>
      (cr[7] && cr[2] && ((cr & 16'h0303) == 16'h0000) && !go_tx && !go_cam));

   assert_rra_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cr[8] && !cmd_w) |=> !cr[8]);

   assert_mask_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !imr[15]);

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_set != '0) |=> ((isr & 16'($past(sts_set))) == 16'($past(sts_set))));

   assert_rbe_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && (host_idx == ADDR_W'(IX_ISTAT)) && host_wdata[RBE_BIT] && isr[RBE_BIT])
      |=> go_rra);

endmodule

bind enet_ctl_regs enet_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_wr      (host_wr),
   .host_idx     (host_idx),
   .host_wdata   (host_wdata),
   .sts_set      (sts_set),
   .cr           (cr_q),
   .imr          (imr_q),
   .isr          (isr_q),
   .go_tx        (go_tx),
   .go_rra       (go_rra),
   .go_cam       (go_cam),
   .go_rx_en     (go_rx_en),
   .go_tmr_start (go_tmr_start)
);

// File: tb/enet_ctl_regs_test.sv
module enet_ctl_regs_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [5:0]  host_idx = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic [15:0] sts_set = '0;
   logic        tx_done = 1'b0;
   logic        cam_done = 1'b0;
   logic        go_tx, go_rra, go_cam, go_tmr_start, go_tmr_stop, go_rx_en, go_rx_dis;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   enet_ctl_regs uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_idx(host_idx),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .sts_set(sts_set),
      .tx_done(tx_done), .cam_done(cam_done), .go_tx(go_tx), .go_rra(go_rra),
      .go_cam(go_cam), .go_tmr_start(go_tmr_start), .go_tmr_stop(go_tmr_stop),
      .go_rx_en(go_rx_en), .go_rx_dis(go_rx_dis), .irq(irq)
   );

   always #4 clk = ~clk;

   typedef struct packed {
      logic [7:0]  req;
      logic [5:0]  idx;
      logic [15:0] wd;
      logic [15:0] exp;
   } vec_t;

   // rule classes R9, R10, R11, R12 while still in reset mode
   localparam vec_t VEC [15] = '{
      '{8'd9,  6'h01, 16'hFFFF, 16'hBFFF},
      '{8'd9,  6'h3F, 16'hFFFF, 16'hF017},
      '{8'd10, 6'h03, 16'hFFFF, 16'hF000},
      '{8'd10, 6'h02, 16'hFFFF, 16'hFFE0},
      '{8'd10, 6'h15, 16'h1235, 16'h1234},
      '{8'd10, 6'h18, 16'hFFFF, 16'hFFFE},
      '{8'd11, 6'h2C, 16'h00FF, 16'hFF00},
      '{8'd11, 6'h2E, 16'h1234, 16'hEDCB},
      '{8'd11, 6'h28, 16'hFFFF, 16'h0004},
      '{8'd11, 6'h23, 16'hFFFF, 16'h0000},
      '{8'd11, 6'h2F, 16'h5555, 16'h0000},
      '{8'd12, 6'h1C, 16'hFFFF, 16'h0000},
      '{8'd12, 6'h35, 16'hFFFF, 16'h0000},
      '{8'd12, 6'h06, 16'hA5A5, 16'hA5A5},
      '{8'd12, 6'h25, 16'hFFFF, 16'hFFFF}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_sts(input logic [5:0] ix, input logic [15:0] d, input logic [15:0] s);
      @(negedge clk);
      host_wr = 1'b1; host_idx = ix; host_wdata = d; sts_set = s;
      @(negedge clk);
      host_wr = 1'b0; sts_set = '0;
   endtask

   task automatic wr(input logic [5:0] ix, input logic [15:0] d);
      wr_sts(ix, d, 16'h0000);
   endtask

   task automatic rd(input logic [5:0] ix, output logic [15:0] v);
      host_idx = ix;
      #1;
      v = host_rdata;
   endtask

   task automatic pulse_sts(input logic [15:0] s);
      @(negedge clk); sts_set = s;
      @(negedge clk); sts_set = '0;
   endtask

   function automatic logic [15:0] pulses();
      return {9'd0, go_tx, go_rra, go_cam, go_tmr_start, go_tmr_stop, go_rx_en, go_rx_dis};
   endfunction

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd(6'h00, v); chk("R1 command", v, 16'h0094);
      rd(6'h03, v); chk("R1 tx control", v, 16'h0101);
      rd(6'h02, v); chk("R1 rx control", v, 16'h0020);
      rd(6'h13, v); chk("R1 end of buffer", v, 16'h02F8);
      rd(6'h04, v); chk("R1 mask", v, 16'h0000);
      rd(6'h05, v); chk("R1 status", v, 16'h0000);
      rd(6'h28, v); chk("R1 revision", v, 16'h0004);
      chk("R1 irq", {15'd0, irq}, 16'h0000);

      foreach (VEC[i]) begin
         wr(VEC[i].idx, VEC[i].wd);
         rd(VEC[i].idx, v);
         checks++;
         if (v !== VEC[i].exp) begin
            errors++;
            $display("FAIL R%0d index %h actual %h expected %h", VEC[i].req, VEC[i].idx, v, VEC[i].exp);
         end
      end

      // R2 leaving reset swallows the write
      wr(6'h00, 16'h0002);
      chk("R2 no pulse", pulses(), 16'h0000);
      rd(6'h00, v); chk("R2 command", v, 16'h0014);

      // R9 reset-only register ignored outside reset
      wr(6'h01, 16'h0000);
      rd(6'h01, v); chk("R9 gated write", v, 16'hBFFF);

      // R3 transmit launch, R6 done
      wr(6'h00, 16'h0002);
      chk("R3 go_tx", pulses(), 16'h0040);
      rd(6'h00, v); chk("R3 command tx", v, 16'h0016);
      @(negedge clk);
      chk("R3 pulse one cycle", pulses(), 16'h0000);
      @(negedge clk); tx_done = 1'b1;
      @(negedge clk); tx_done = 1'b0;
      rd(6'h00, v); chk("R6 tx_done clears", v, 16'h0014);

      // R4 pair exclusion
      wr(6'h00, 16'h0008);
      chk("R4 go_rx_en", pulses(), 16'h0002);
      rd(6'h00, v); chk("R4 enable clears disable", v, 16'h0018);
      wr(6'h00, 16'h0020);
      chk("R4 go_tmr_start", pulses(), 16'h0008);
      rd(6'h00, v); chk("R4 start clears stop", v, 16'h0028);
      wr(6'h00, 16'h0014);
      chk("R4 disable and stop pulses", pulses(), 16'h0005);
      rd(6'h00, v); chk("R4 disable and stop", v, 16'h0014);
      wr(6'h00, 16'h003C);
      rd(6'h00, v); chk("R4 both written", v, 16'h0028);

      // R3 unstored bits
      wr(6'h00, 16'hFC40);
      chk("R3 unstored no pulse", pulses(), 16'h0000);
      rd(6'h00, v); chk("R3 unstored bits", v, 16'h0028);

      // R6 resource-read self clear
      wr(6'h00, 16'h0100);
      chk("R3 go_rra", pulses(), 16'h0020);
      rd(6'h00, v); chk("R6 rra set", v, 16'h0128);
      @(negedge clk);
      rd(6'h00, v); chk("R6 rra self clear", v, 16'h0028);

      // R6 filter load done
      wr(6'h00, 16'h0200);
      chk("R3 go_cam", pulses(), 16'h0010);
      @(negedge clk); cam_done = 1'b1;
      @(negedge clk); cam_done = 1'b0;
      rd(6'h00, v); chk("R6 cam_done clears", v, 16'h0028);

      // R5 software reset over pending launches
      wr(6'h00, 16'h0202);
      chk("R3 tx and cam pulses", pulses(), 16'h0050);
      wr(6'h00, 16'h0081);
      chk("R5 pulses", pulses(), 16'h0001);
      rd(6'h00, v); chk("R5 command", v, 16'h00A4);
      wr(6'h00, 16'h0000);
      rd(6'h00, v); chk("R2 exit again", v, 16'h0024);

      // R7 and R8 interrupt path
      wr(6'h04, 16'hFFFF);
      rd(6'h04, v); chk("R7 mask bit 15", v, 16'h7FFF);
      pulse_sts(16'h8000);
      rd(6'h05, v); chk("R8 set top", v, 16'h8000);
      chk("R7 masked irq", {15'd0, irq}, 16'h0000);
      pulse_sts(16'h0020);
      rd(6'h05, v); chk("R8 set rbe", v, 16'h8020);
      chk("R7 irq high", {15'd0, irq}, 16'h0001);
      wr(6'h05, 16'h8001);
      chk("R8 no rra", {15'd0, go_rra}, 16'h0000);
      rd(6'h05, v); chk("R8 partial clear", v, 16'h0020);
      wr(6'h05, 16'h0020);
      chk("R8 rra request", {15'd0, go_rra}, 16'h0001);
      rd(6'h05, v); chk("R8 cleared", v, 16'h0000);
      chk("R7 irq low", {15'd0, irq}, 16'h0000);
      wr(6'h05, 16'h0020);
      chk("R8 clear of clear bit", {15'd0, go_rra}, 16'h0000);
      pulse_sts(16'h0080);
      wr_sts(6'h05, 16'h0080, 16'h0080);
      rd(6'h05, v); chk("R8 set priority", v, 16'h0080);
      chk("R7 irq on bit 7", {15'd0, irq}, 16'h0001);
      wr(6'h04, 16'h0000);
      chk("R7 mask off", {15'd0, irq}, 16'h0000);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule